// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is the arithmetic and flag engine for an 8-bit two-accumulator machine. The two accumulators, A and B, join to form a 16-bit D register, and a 16-bit index register X sits beside them. On each cycle where `in_valid` is high, the block takes an operation code, two operands and the packed condition-code byte. One clock later it presents the result and the next condition-code byte on registered outputs. Instruction decode, memory access and instruction timing belong to the surrounding core. That core routes A, B, D or X onto the operand inputs and writes the result back.

The condition codes form one byte. Bit 5 is H (half carry), bit 4 is I (interrupt mask), bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. Bits 7 and 6 are kept as they are stored. The operations cover 8-bit arithmetic, logic, shifts and rotates. They also cover 16-bit add, subtract and shifts on D, an 8x8 multiply, an index add that leaves the flags alone, moves between A and the flag byte, and individual set and clear of C, I and V.

For 8-bit operations the operands are taken from `opa[7:0]` and `opb[7:0]`. For 16-bit operations the block uses the full width. Each 8-bit result leaves the upper byte at zero.

Top module: `accum_alu`

## Requirements
- R1: Flag byte layout is H=bit5, I=bit4, N=bit3, Z=bit2, V=bit1, C=bit0. Every operation except code 23 passes bits 7:6 through from `cc_in`. Code 23 (A to flags) loads all eight bits from `opa[7:0]` and returns `opa` as the result. Code 24 (flags to A) returns `cc_in` zero-extended as the result and leaves the flags unchanged.
- R2: Code 0 (add) and code 1 (add with C) give result a+b(+C) in the low byte with the upper byte zero. H is the carry out of bit 3, N is bit 7, Z marks a zero byte, V marks signed overflow and C is the carry out of bit 7. I is unchanged.
- R3: Code 2 (subtract) and code 3 (subtract with C) give a-b(-C). C is the borrow, V marks signed overflow, N and Z follow the result byte, and H is unchanged.
- R4: Codes 4, 5 and 6 (AND, OR, XOR) set N and Z, clear V and leave C alone. Code 7 (complement) gives ~a, clears V and sets C.
- R5: Code 8 (negate) gives 0-a, with V set only for 0x80 and C set for any nonzero a. Code 9 (increment) sets V only when a is 0x7F. Code 10 (decrement) sets V only when a is 0x80. Codes 9 and 10 leave C unchanged.
- R6: Code 11 (clear) gives zero, sets Z, clears N, V and C, and keeps H and I.
- R7: Codes 12 to 16 are shift left, arithmetic shift right, logical shift right, rotate left through C and rotate right through C. In each, C takes the bit shifted out and V = N XOR C. Logical shift right clears N.
- R8: Code 17 (D+M) and code 18 (D-M) are 16-bit operations. N is bit 15, Z tests all 16 bits, V marks signed overflow, C is the carry or borrow, and H is unchanged.
- R9: Code 19 (D shift left) takes C from bit 15. Code 20 (D logical shift right) takes C from bit 0 and clears N. Both set V = N XOR C.
- R10: Code 21 (multiply) returns the 16-bit product of `opa[7:0]` and `opb[7:0]`. C is set equal to bit 7 of the product, and every other flag is unchanged.
- R11: Code 22 (index add) returns `opa` plus `opb[7:0]` as an unsigned value, wrapping modulo 2^16, and no flag changes.
- R12: Codes 25 to 30 set C, clear C, set I, clear I, set V and clear V. Each changes only its own flag and returns `opa` as the result.
- R13: Reset clears `res_q`, `cc_q` and `out_valid`. The outputs update one clock after `in_valid` is high, and `out_valid` follows `in_valid` by one clock. While `in_valid` is low, `res_q` and `cc_q` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 5 | Operation code (0 to 30) |
| opa | input | 16 | First operand (A, D or X) |
| opb | input | 16 | Second operand (B or memory value) |
| cc_in | input | 8 | Current packed flag byte |
| out_valid | output | 1 | Result registered from the previous cycle |
| res_q | output | 16 | Registered result |
| cc_q | output | 8 | Registered next flag byte |

## Verification
The bench builds the block with its default 8-bit data width, so D, X and the product are 16 bits wide. At that width the signed and unsigned boundaries are easy to reach with directly written operands: 0x7F, 0x80, 0xFF and 0x7FFF, 0xFFFF. That lets every overflow, borrow and half-carry case in the requirements be hit exactly. The table also uses results whose low byte is zero and whose high byte is not, which shows that Z tests the full 16 bits. Seeding `cc_in` with bits 7:6 set shows that those bits survive every operation except the load from A.

// File: rtl/accum_alu_pkg.sv
`timescale 1ns/1ps
// Shared operation codes and flag-byte bit positions for the accumulator ALU.
// Assumes an 8-bit flag byte whose layout is fixed by the instruction set.
package accum_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_EOR  = 5'd6,  OP_COM  = 5'd7,
        OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_CLR  = 5'd11,
        OP_ASL  = 5'd12, OP_ASR  = 5'd13, OP_LSR  = 5'd14, OP_ROL  = 5'd15,
        OP_ROR  = 5'd16, OP_ADDW = 5'd17, OP_SUBW = 5'd18, OP_ASLW = 5'd19,
        OP_LSRW = 5'd20, OP_MUL  = 5'd21, OP_IDXA = 5'd22, OP_A2CC = 5'd23,
        OP_CC2A = 5'd24, OP_SETC = 5'd25, OP_CLRC = 5'd26, OP_SETI = 5'd27,
        OP_CLRI = 5'd28, OP_SETV = 5'd29, OP_CLRV = 5'd30, OP_NONE = 5'd31
    } alu_op_e;

    localparam int unsigned CC_W = 8;
    localparam int unsigned CC_H = 5;
    localparam int unsigned CC_I = 4;
    localparam int unsigned CC_N = 3;
    localparam int unsigned CC_Z = 2;
    localparam int unsigned CC_V = 1;
    localparam int unsigned CC_C = 0;

endpackage

// File: rtl/alu_byte_unit.sv
`timescale 1ns/1ps
// Single-width arithmetic, logic, shift and rotate unit with flag update.
// Purely combinational. Outputs are only meaningful for byte operation codes.
// Assumes DW is even and at least 4, so that the half-carry bit exists.
module alu_byte_unit
    import accum_alu_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    a,
    input  logic [DW-1:0]    b,
    input  logic [CC_W-1:0]  cc_in,
    output logic [DW-1:0]    res,
    output logic [CC_W-1:0]  cc_out
);
    localparam int unsigned NIB = DW / 2;
    localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MAX_POS = ~MIN_NEG;

    logic          cin;
    logic [DW:0]   sum;
    logic [DW:0]   diff;
    logic          h_nx, v_nx, c_nx;

    // Carry-in is only used by the with-carry forms.
    assign cin  = ((op == OP_ADC) || (op == OP_SBC)) ? cc_in[CC_C] : 1'b0;
    assign sum  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    assign diff = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};

    // Select the result and the H, V and C rules for each byte operation.
    always_comb begin
        res  = '0;
        h_nx = cc_in[CC_H];
        v_nx = cc_in[CC_V];
        c_nx = cc_in[CC_C];
        case (op)
            OP_ADD, OP_ADC: begin
                res  = sum[DW-1:0];
                h_nx = a[NIB] ^ b[NIB] ^ sum[NIB];
                v_nx = (a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]);
                c_nx = sum[DW];
            end
            OP_SUB, OP_SBC: begin
                res  = diff[DW-1:0];
                v_nx = (a[DW-1] != b[DW-1]) && (diff[DW-1] != a[DW-1]);
                c_nx = diff[DW];
            end
            OP_AND: begin res = a & b; v_nx = 1'b0; end
            OP_OR:  begin res = a | b; v_nx = 1'b0; end
            OP_EOR: begin res = a ^ b; v_nx = 1'b0; end
            OP_COM: begin res = ~a; v_nx = 1'b0; c_nx = 1'b1; end
            OP_NEG: begin
                res  = '0 - a;
                v_nx = (a == MIN_NEG);
                c_nx = (a != '0);
            end
            OP_INC: begin res = a + DW'(1); v_nx = (a == MAX_POS); end
            OP_DEC: begin res = a - DW'(1); v_nx = (a == MIN_NEG); end
            OP_CLR: begin res = '0; v_nx = 1'b0; c_nx = 1'b0; end
            OP_ASL: begin
                res  = {a[DW-2:0], 1'b0};
                c_nx = a[DW-1];
                v_nx = a[DW-2] ^ a[DW-1];
            end
            OP_ASR: begin
                res  = {a[DW-1], a[DW-1:1]};
                c_nx = a[0];
                v_nx = a[DW-1] ^ a[0];
            end
            OP_LSR: begin
                res  = {1'b0, a[DW-1:1]};
                c_nx = a[0];
                v_nx = a[0];
            end
            OP_ROL: begin
                res  = {a[DW-2:0], cc_in[CC_C]};
                c_nx = a[DW-1];
                v_nx = a[DW-2] ^ a[DW-1];
            end
            OP_ROR: begin
                res  = {cc_in[CC_C], a[DW-1:1]};
                c_nx = a[0];
                v_nx = cc_in[CC_C] ^ a[0];
            end
            default: res = a;
        endcase
    end

    // Pack the new flags. I and bits 7:6 pass through.
    always_comb begin
        cc_out       = cc_in;
        cc_out[CC_H] = h_nx;
        cc_out[CC_N] = res[DW-1];
        cc_out[CC_Z] = (res == '0);
        cc_out[CC_V] = v_nx;
        cc_out[CC_C] = c_nx;
    end

endmodule

// File: rtl/alu_wide_unit.sv
`timescale 1ns/1ps
// Double-width unit for the D register and the index register: add, subtract,
// shifts, multiply and the flag-neutral index add. Combinational. Never
// touches H, and leaves the flags it does not own as they came in.
module alu_wide_unit
    import accum_alu_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  alu_op_e          op,
    input  logic [2*DW-1:0]  d,
    input  logic [2*DW-1:0]  m,
    input  logic [CC_W-1:0]  cc_in,
    output logic [2*DW-1:0]  res,
    output logic [CC_W-1:0]  cc_out
);
    localparam int unsigned WW = 2 * DW;

    logic [WW:0]   wsum;
    logic [WW:0]   wdiff;
    logic [WW-1:0] prod;

    assign wsum  = {1'b0, d} + {1'b0, m};
    assign wdiff = {1'b0, d} - {1'b0, m};
    assign prod  = {{DW{1'b0}}, d[DW-1:0]} * {{DW{1'b0}}, m[DW-1:0]};

    // Per-operation result and flag update on the double-width path.
    always_comb begin
        res    = d;
        cc_out = cc_in;
        case (op)
            OP_ADDW: begin
                res          = wsum[WW-1:0];
                cc_out[CC_V] = (d[WW-1] == m[WW-1]) && (wsum[WW-1] != d[WW-1]);
                cc_out[CC_C] = wsum[WW];
            end
            OP_SUBW: begin
                res          = wdiff[WW-1:0];
                cc_out[CC_V] = (d[WW-1] != m[WW-1]) && (wdiff[WW-1] != d[WW-1]);
                cc_out[CC_C] = wdiff[WW];
            end
            OP_ASLW: begin
                res          = {d[WW-2:0], 1'b0};
                cc_out[CC_C] = d[WW-1];
                cc_out[CC_V] = d[WW-2] ^ d[WW-1];
            end
            OP_LSRW: begin
                res          = {1'b0, d[WW-1:1]};
                cc_out[CC_C] = d[0];
                cc_out[CC_V] = d[0];
            end
            OP_MUL: begin
                res          = prod;
                cc_out[CC_C] = prod[DW-1];
            end
            OP_IDXA: res = d + {{DW{1'b0}}, m[DW-1:0]};
            default: res = d;
        endcase
        if (op == OP_ADDW || op == OP_SUBW || op == OP_ASLW || op == OP_LSRW) begin
            cc_out[CC_N] = res[WW-1];
            cc_out[CC_Z] = (res == '0);
        end
    end

endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/1ps
// Flag-register moves and single-flag set/clear operations. Combinational.
// Assumes the result width is at least the flag byte width.
module alu_flag_unit
    import accum_alu_pkg::*;
#(
    parameter int unsigned WW = 16
) (
    input  alu_op_e          op,
    input  logic [WW-1:0]    a,
    input  logic [CC_W-1:0]  cc_in,
    output logic [WW-1:0]    res,
    output logic [CC_W-1:0]  cc_out
);
    // Move between A and the flag byte, or force one flag.
    always_comb begin
        res    = a;
        cc_out = cc_in;
        case (op)
            OP_A2CC: cc_out = a[CC_W-1:0];
            OP_CC2A: res    = {{(WW-CC_W){1'b0}}, cc_in};
            OP_SETC: cc_out[CC_C] = 1'b1;
            OP_CLRC: cc_out[CC_C] = 1'b0;
            OP_SETI: cc_out[CC_I] = 1'b1;
            OP_CLRI: cc_out[CC_I] = 1'b0;
            OP_SETV: cc_out[CC_V] = 1'b1;
            OP_CLRV: cc_out[CC_V] = 1'b0;
            default: cc_out = cc_in;
        endcase
    end

endmodule

// File: rtl/accum_alu.sv
`timescale 1ns/1ps
// Accumulator ALU top: routes the operation to the byte, wide or flag unit
// and registers the selected result and flag byte for one cycle.
// Assumes the surrounding core supplies operands and the current flag byte.
module accum_alu
    import accum_alu_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [4:0]          op,
    input  logic [2*DW-1:0]     opa,
    input  logic [2*DW-1:0]     opb,
    input  logic [CC_W-1:0]     cc_in,
    output logic                out_valid,
    output logic [2*DW-1:0]     res_q,
    output logic [CC_W-1:0]     cc_q
);
    localparam int unsigned WW = 2 * DW;

    alu_op_e         op_e;
    logic [DW-1:0]   byte_res;
    logic [CC_W-1:0] byte_cc;
    logic [WW-1:0]   wide_res;
    logic [CC_W-1:0] wide_cc;
    logic [WW-1:0]   flag_res;
    logic [CC_W-1:0] flag_cc;
    logic [WW-1:0]   nxt_res;
    logic [CC_W-1:0] nxt_cc;

    assign op_e = alu_op_e'(op);

    alu_byte_unit #(.DW(DW)) u_byte (
        .op(op_e), .a(opa[DW-1:0]), .b(opb[DW-1:0]), .cc_in(cc_in),
        .res(byte_res), .cc_out(byte_cc)
    );

    alu_wide_unit #(.DW(DW)) u_wide (
        .op(op_e), .d(opa), .m(opb), .cc_in(cc_in),
        .res(wide_res), .cc_out(wide_cc)
    );

    alu_flag_unit #(.WW(WW)) u_flag (
        .op(op_e), .a(opa), .cc_in(cc_in),
        .res(flag_res), .cc_out(flag_cc)
    );

    // Pick the unit that owns the current operation code range.
    always_comb begin
        if (op_e <= OP_ROR) begin
            nxt_res = {{DW{1'b0}}, byte_res};
            nxt_cc  = byte_cc;
        end else if (op_e <= OP_IDXA) begin
            nxt_res = wide_res;
            nxt_cc  = wide_cc;
        end else begin
            nxt_res = flag_res;
            nxt_cc  = flag_cc;
        end
    end

    // Output register: capture on a valid request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_q     <= '0;
            cc_q      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= nxt_res;
                cc_q  <= nxt_cc;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R13
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_q) && $stable(cc_q) && !out_valid)); // R13
    AST_TOP_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e != OP_A2CC) |=> (cc_q[7:6] == $past(cc_in[7:6]))); // R1
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_CLR) |=> (res_q == '0 && cc_q[CC_Z] && !cc_q[CC_C])); // R6
    AST_LSR_N_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_e == OP_LSR || op_e == OP_LSRW)) |=> !cc_q[CC_N]); // R7
    AST_MUL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_MUL) |=> (cc_q[CC_C] == res_q[DW-1])); // R10
    AST_IDX_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_e == OP_IDXA) |=> (cc_q == $past(cc_in))); // R11

endmodule

// File: tb/tb_accum_alu.sv
`timescale 1ns/1ps
// Table-driven bench for accum_alu followed by directed reset and hold tests.
module tb_accum_alu;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [4:0]  op;
    logic [15:0] opa, opb;
    logic [7:0]  cc_in;
    logic        out_valid;
    logic [15:0] res_q;
    logic [7:0]  cc_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    accum_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .cc_in(cc_in),
        .out_valid(out_valid), .res_q(res_q), .cc_q(cc_q)
    );

    // {req, op, opa, opb, cc_in, expected result, expected flags}
    localparam int NV = 41;
    localparam logic [72:0] VEC [NV] = '{
        {4'd2,  5'd0,  16'hAB3A, 16'h0048, 8'h00, 16'h0082, 8'h2A}, // R2 H,N,V
        {4'd2,  5'd0,  16'h00FF, 16'h0001, 8'hC0, 16'h0000, 8'hE5}, // R2 wrap, R1 top bits
        {4'd2,  5'd1,  16'h0010, 16'h0020, 8'h11, 16'h0031, 8'h10}, // R2 carry in, I kept
        {4'd3,  5'd2,  16'h0010, 16'h0020, 8'h20, 16'h00F0, 8'h29}, // R3 borrow, H kept
        {4'd3,  5'd2,  16'h0080, 16'h0001, 8'h00, 16'h007F, 8'h02}, // R3 overflow
        {4'd3,  5'd3,  16'h0005, 16'h0005, 8'h01, 16'h00FF, 8'h09}, // R3 borrow in
        {4'd3,  5'd3,  16'h0005, 16'h0005, 8'h00, 16'h0000, 8'h04}, // R3 zero
        {4'd4,  5'd4,  16'h00F0, 16'h000F, 8'h03, 16'h0000, 8'h05}, // R4 AND
        {4'd4,  5'd5,  16'h0080, 16'h0001, 8'h02, 16'h0081, 8'h08}, // R4 OR
        {4'd4,  5'd6,  16'h00FF, 16'h000F, 8'h00, 16'h00F0, 8'h08}, // R4 XOR
        {4'd4,  5'd7,  16'h00FF, 16'h0000, 8'h02, 16'h0000, 8'h05}, // R4 complement
        {4'd5,  5'd8,  16'h0080, 16'h0000, 8'h00, 16'h0080, 8'h0B}, // R5 negate 0x80
        {4'd5,  5'd8,  16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h04}, // R5 negate zero
        {4'd5,  5'd9,  16'h007F, 16'h0000, 8'h01, 16'h0080, 8'h0B}, // R5 increment
        {4'd5,  5'd10, 16'h0080, 16'h0000, 8'h00, 16'h007F, 8'h02}, // R5 decrement
        {4'd6,  5'd11, 16'h0055, 16'h0000, 8'h3B, 16'h0000, 8'h34}, // R6 clear
        {4'd7,  5'd12, 16'h0081, 16'h0000, 8'h00, 16'h0002, 8'h03}, // R7 shift left
        {4'd7,  5'd13, 16'h0081, 16'h0000, 8'h00, 16'h00C0, 8'h09}, // R7 arith right
        {4'd7,  5'd14, 16'h0001, 16'h0000, 8'h00, 16'h0000, 8'h07}, // R7 logic right
        {4'd7,  5'd15, 16'h0040, 16'h0000, 8'h01, 16'h0081, 8'h0A}, // R7 rotate left
        {4'd7,  5'd16, 16'h0001, 16'h0000, 8'h01, 16'h0080, 8'h09}, // R7 rotate right
        {4'd8,  5'd17, 16'h7FFF, 16'h0001, 8'h20, 16'h8000, 8'h2A}, // R8 overflow, H kept
        {4'd8,  5'd17, 16'hFFFF, 16'h0001, 8'h00, 16'h0000, 8'h05}, // R8 carry, zero
        {4'd8,  5'd18, 16'h1200, 16'h1100, 8'h00, 16'h0100, 8'h00}, // R8 Z over 16 bits
        {4'd8,  5'd18, 16'h0000, 16'h0001, 8'h00, 16'hFFFF, 8'h09}, // R8 borrow
        {4'd9,  5'd19, 16'h8001, 16'h0000, 8'h00, 16'h0002, 8'h03}, // R9 carry from bit 15
        {4'd9,  5'd19, 16'h4000, 16'h0000, 8'h00, 16'h8000, 8'h0A}, // R9 V from N
        {4'd9,  5'd20, 16'h0001, 16'h0000, 8'h00, 16'h0000, 8'h07}, // R9 carry from bit 0
        {4'd9,  5'd20, 16'h0200, 16'h0000, 8'h00, 16'h0100, 8'h00}, // R9 Z over 16 bits
        {4'd10, 5'd21, 16'h000C, 16'h000C, 8'h2E, 16'h0090, 8'h2F}, // R10 C from bit 7
        {4'd10, 5'd21, 16'h00FF, 16'h00FF, 8'h01, 16'hFE01, 8'h00}, // R10 max product
        {4'd11, 5'd22, 16'hFFF0, 16'h0020, 8'hFF, 16'h0010, 8'hFF}, // R11 wrap
        {4'd11, 5'd22, 16'h1234, 16'h0080, 8'h00, 16'h12B4, 8'h00}, // R11 unsigned B
        {4'd1,  5'd23, 16'h00D5, 16'h0000, 8'h00, 16'h00D5, 8'hD5}, // R1 A to flags
        {4'd1,  5'd24, 16'h1234, 16'h0000, 8'h6A, 16'h006A, 8'h6A}, // R1 flags to A
        {4'd12, 5'd25, 16'h1234, 16'h0000, 8'h40, 16'h1234, 8'h41}, // R12 set C
        {4'd12, 5'd26, 16'h0000, 16'h0000, 8'hFF, 16'h0000, 8'hFE}, // R12 clear C
        {4'd12, 5'd27, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h10}, // R12 set I
        {4'd12, 5'd28, 16'h0000, 16'h0000, 8'hFF, 16'h0000, 8'hEF}, // R12 clear I
        {4'd12, 5'd29, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h02}, // R12 set V
        {4'd12, 5'd30, 16'h0000, 16'h0000, 8'hFF, 16'h0000, 8'hFD}  // R12 clear V
    };

    task automatic check(input string tag, input logic [15:0] act_r, input logic [15:0] exp_r,
                         input logic [7:0] act_c, input logic [7:0] exp_c);
        n_chk++;
        if (act_r !== exp_r || act_c !== exp_c) begin
            n_fail++;
            $display("FAIL %s: result %h flags %h, expected result %h flags %h",
                     tag, act_r, act_c, exp_r, exp_c);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op = 5'd0;
        opa = 16'hFFFF; opb = 16'hFFFF; cc_in = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13 reset state
        check("R13 reset", res_q, 16'h0000, cc_q, 8'h00);
        check("R13 reset valid", {15'd0, out_valid}, 16'h0000, 8'h00, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            op       = VEC[i][68:64];
            opa      = VEC[i][63:48];
            opb      = VEC[i][47:32];
            cc_in    = VEC[i][31:24];
            in_valid = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i][72:69], i),
                  res_q, VEC[i][23:8], cc_q, VEC[i][7:0]);
        end
        // R13 valid follows the request
        check("R13 out_valid high", {15'd0, out_valid}, 16'h0001, 8'h00, 8'h00);

        // R13 idle hold: a clear request without in_valid changes nothing
        in_valid = 1'b0; op = 5'd11; opa = 16'h5555; cc_in = 8'h00;
        @(negedge clk);
        check("R13 hold idle", res_q, 16'h0000, cc_q, 8'hFD);
        check("R13 out_valid low", {15'd0, out_valid}, 16'h0000, 8'h00, 8'h00);

        // R2 back-to-back requests with different carry inputs
        in_valid = 1'b1; op = 5'd1; opa = 16'h000F; opb = 16'h0000; cc_in = 8'h01;
        @(negedge clk);
        check("R2 adc nibble carry", res_q, 16'h0010, cc_q, 8'h20);
        cc_in = 8'h00;
        @(negedge clk);
        check("R2 adc no carry", res_q, 16'h000F, cc_q, 8'h00);

        // R13 reset while a request is presented
        op = 5'd0; opa = 16'h0011; opb = 16'h0022; rst_n = 1'b0;
        @(negedge clk);
        check("R13 reset mid-run", res_q, 16'h0000, cc_q, 8'h00);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule